// File: doc/BRIEF.md
# Two-Phase Toggle Handshake Link

This block carries one data word at a time from a requester clock domain to a responder clock domain. It uses non-return-to-zero transition signaling. A transaction is opened by a single change of level on the request line and closed by a single change of level on the acknowledge line. Neither line goes back to zero between transactions. Each side keeps its own line as a phase bit, so it always knows which level counts as "new".

The requester side works like a four-phase bridge. It offers a ready indication and takes a one-cycle send strobe together with a data word. The responder side shows a data-valid flag with the word, and takes a done strobe once the word has been used. Each side passes the other side's line through a two-flop synchronizer and then compares it with its own phase bit. The requester is idle when the synchronized acknowledge equals its request level. The responder has work pending when the synchronized request differs from its acknowledge level. The data word is held in a requester register and is not synchronized. It is left unchanged from the request toggle until the matching acknowledge toggle has been seen.

Top module: `toggle_handshake`

## Requirements
- R1: After reset both phase bits are 0, so both link lines start low. `snd_ready` is 1 and `rcv_valid` is 0.
- R2: A send strobe sampled while `snd_ready` is 1 toggles the request line and captures `snd_data`. `snd_ready` reads 0 from the next requester clock on.
- R3: A send strobe sampled while `snd_ready` is 0 is ignored. No further transaction starts and the captured word is unchanged.
- R4: `rcv_valid` becomes 1 after the second responder clock edge that follows the request toggle. While it is 1, `rcv_data` equals the captured word.
- R5: A done strobe sampled while `rcv_valid` is 1 toggles the acknowledge line, and `rcv_valid` reads 0 from the next responder clock on. A done strobe sampled while `rcv_valid` is 0 is ignored, so `snd_ready` stays 1 and `rcv_valid` stays 0.
- R6: `snd_ready` returns to 1 after the second requester clock edge that follows the acknowledge toggle.
- R7: Consecutive transactions alternate the sense of the lines: the first is a rising request answered by a rising acknowledge, the next a falling request answered by a falling acknowledge. Every transaction completes with its own word.
- R8: A send strobe held high is accepted on the very first requester clock edge at which `snd_ready` is 1 after a completion, giving back-to-back transactions.
- R9: `rcv_data` does not change while a transaction is open, even when `snd_data` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Requester clock |
| rst_a_n | input | 1 | Requester asynchronous active-low reset |
| snd_go | input | 1 | Send strobe, one transaction per accepted cycle |
| snd_data | input | DW | Word to send |
| snd_ready | output | 1 | Requester idle, a send strobe will be accepted |
| clk_b | input | 1 | Responder clock |
| rst_b_n | input | 1 | Responder asynchronous active-low reset |
| rcv_valid | output | 1 | A new word is waiting on `rcv_data` |
| rcv_data | output | DW | Word of the open transaction |
| rcv_done | input | 1 | Responder finished with the word |

## Verification
Two events can fall in the same requester cycle: completion detection (the synchronized acknowledge matching the request phase) and acceptance of the next send strobe. The bench holds the send strobe high through a whole transaction with a second word already on the input. It then checks that `snd_ready` is high for exactly the one cycle of that edge, that the strobe is taken there, and that the second word arrives with the correct latency. On the responder side, a done strobe is given in the first cycle `rcv_valid` is seen. A done strobe on an idle link is also given and must leave both sides unchanged.

// File: rtl/toggle_hs_pkg.sv
package toggle_hs_pkg;
  localparam int unsigned SYNC_DEPTH = 2;

  typedef enum logic [0:0] {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_t;

  function automatic phase_t flip(input phase_t p);
    return (p == PH_LOW) ? PH_HIGH : PH_LOW;
  endfunction
endpackage

// File: rtl/toggle_hs_sync.sv
module toggle_hs_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign chain_d[i] = d;
      end else begin : g_next
        assign chain_d[i] = chain_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/toggle_hs_req_side.sv
module toggle_hs_req_side
  import toggle_hs_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [DW-1:0] data_in,
  output logic          ready,
  output logic          line_req,
  output logic [DW-1:0] line_data,
  input  logic          line_ack
);
  phase_t        req_q, req_d;
  logic [DW-1:0] word_q, word_d;
  logic          ack_s;
  logic          take;

  toggle_hs_sync #(.STAGES(SYNC_DEPTH)) u_ack_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (line_ack),
    .q     (ack_s)
  );

  // Idle when the returned acknowledge matches our own phase.
  assign ready = (ack_s == logic'(req_q));
  assign take  = go && ready;

  always_comb begin
    req_d  = req_q;
    word_d = word_q;
    if (take) begin
      req_d  = flip(req_q);
      word_d = data_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= PH_LOW;
      word_q <= '0;
    end else if (take) begin
      req_q  <= req_d;
      word_q <= word_d;
    end
  end

  assign line_req  = logic'(req_q);
  assign line_data = word_q;

  assert_busy_after_send_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !ready);
  assert_busy_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> $stable(line_req));
  assert_word_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> $stable(line_data));
endmodule

// File: rtl/toggle_hs_ack_side.sv
module toggle_hs_ack_side
  import toggle_hs_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_req,
  input  logic [DW-1:0] line_data,
  output logic          line_ack,
  output logic          valid,
  output logic [DW-1:0] data_out,
  input  logic          done
);
  phase_t ack_q, ack_d;
  logic   req_s;
  logic   finish;

  toggle_hs_sync #(.STAGES(SYNC_DEPTH)) u_req_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (line_req),
    .q     (req_s)
  );

  // Pending when the synchronized request differs from our phase.
  assign valid  = (req_s != logic'(ack_q));
  assign finish = done && valid;

  always_comb begin
    ack_d = ack_q;
    if (finish) ack_d = flip(ack_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ack_q <= PH_LOW;
    else if (finish) ack_q <= ack_d;
  end

  assign line_ack = logic'(ack_q);
  assign data_out = line_data;

  assert_done_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !valid);
  assert_idle_done_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !valid) |=> $stable(line_ack));
  assert_pending_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !done) |=> valid);
  assert_data_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !done) |=> $stable(data_out));
endmodule

// File: rtl/toggle_handshake.sv
module toggle_handshake #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_a,
  input  logic          rst_a_n,
  input  logic          snd_go,
  input  logic [DW-1:0] snd_data,
  output logic          snd_ready,
  input  logic          clk_b,
  input  logic          rst_b_n,
  output logic          rcv_valid,
  output logic [DW-1:0] rcv_data,
  input  logic          rcv_done
);
  logic          link_req;
  logic          link_ack;
  logic [DW-1:0] link_data;

  toggle_hs_req_side #(.DW(DW)) u_req (
    .clk       (clk_a),
    .rst_n     (rst_a_n),
    .go        (snd_go),
    .data_in   (snd_data),
    .ready     (snd_ready),
    .line_req  (link_req),
    .line_data (link_data),
    .line_ack  (link_ack)
  );

  toggle_hs_ack_side #(.DW(DW)) u_ack (
    .clk       (clk_b),
    .rst_n     (rst_b_n),
    .line_req  (link_req),
    .line_data (link_data),
    .line_ack  (link_ack),
    .valid     (rcv_valid),
    .data_out  (rcv_data),
    .done      (rcv_done)
  );

  assert_reset_idle_R1: assert property (@(posedge clk_a)
    !rst_a_n |-> snd_ready);
endmodule

// File: tb/toggle_handshake_tb.sv
module toggle_handshake_tb;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          snd_go;
  logic [DW-1:0] snd_data;
  logic          snd_ready;
  logic          rcv_valid;
  logic [DW-1:0] rcv_data;
  logic          rcv_done;

  int total  = 0;
  int failed = 0;

  always #5 clk = ~clk;

  toggle_handshake #(.DW(DW)) u_dut (
    .clk_a     (clk),
    .rst_a_n   (rst_n),
    .snd_go    (snd_go),
    .snd_data  (snd_data),
    .snd_ready (snd_ready),
    .clk_b     (clk),
    .rst_b_n   (rst_n),
    .rcv_valid (rcv_valid),
    .rcv_data  (rcv_data),
    .rcv_done  (rcv_done)
  );

  task automatic chk(input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic nclk();
    @(negedge clk);
  endtask

  // Full transaction; caller leaves go low. Checks R2, R4, R5, R6, R9.
  task automatic transact(input logic [DW-1:0] w);
    snd_go = 1'b1; snd_data = w;
    nclk();
    snd_go = 1'b0;
    chk(snd_ready, 0, "R2 ready drops after send");
    chk(rcv_valid, 0, "R4 valid not yet (1 edge)");
    nclk();
    chk(rcv_valid, 0, "R4 valid not yet (2 edges)");
    nclk();
    chk(rcv_valid, 1, "R4 valid after two edges");
    chk(rcv_data, w, "R4 word delivered");
    snd_data = ~w;
    nclk();
    chk(rcv_data, w, "R9 word stable while open");
    rcv_done = 1'b1;
    nclk();
    rcv_done = 1'b0;
    chk(rcv_valid, 0, "R5 valid clears after done");
    chk(snd_ready, 0, "R6 ready still low (1 edge)");
    nclk();
    chk(snd_ready, 0, "R6 ready still low (2 edges)");
    nclk();
    chk(snd_ready, 1, "R6 ready back after two edges");
  endtask

  task automatic t_reset();
    chk(snd_ready, 1, "R1 ready after reset");
    chk(rcv_valid, 0, "R1 valid after reset");
  endtask

  task automatic t_alternate();
    transact(8'hA5);
    transact(8'h3C);
    transact(8'hF0);
    chk(rcv_valid, 0, "R7 link idle after three transactions");
  endtask

  task automatic t_busy_go();
    snd_go = 1'b1; snd_data = 8'h11;
    nclk();
    snd_data = 8'h99;
    nclk();
    snd_go = 1'b0;
    nclk();
    chk(rcv_valid, 1, "R3 first word pending");
    chk(rcv_data, 8'h11, "R3 busy strobe did not replace word");
    rcv_done = 1'b1;
    nclk();
    rcv_done = 1'b0;
    repeat (6) nclk();
    chk(snd_ready, 1, "R3 no extra transaction (ready)");
    chk(rcv_valid, 0, "R3 no extra transaction (valid)");
  endtask

  task automatic t_idle_done();
    rcv_done = 1'b1;
    nclk();
    rcv_done = 1'b0;
    repeat (4) nclk();
    chk(snd_ready, 1, "R5 idle done leaves ready high");
    chk(rcv_valid, 0, "R5 idle done leaves valid low");
  endtask

  task automatic t_back_to_back();
    snd_go = 1'b1; snd_data = 8'h5A;
    nclk();
    snd_data = 8'hC3;
    nclk();
    nclk();
    chk(rcv_data, 8'h5A, "R8 first word");
    rcv_done = 1'b1;
    nclk();
    rcv_done = 1'b0;
    nclk();
    nclk();
    chk(snd_ready, 1, "R8 ready high one cycle");
    nclk();
    snd_go = 1'b0;
    chk(snd_ready, 0, "R8 held strobe taken at once");
    nclk();
    chk(rcv_valid, 0, "R8 second word not yet");
    nclk();
    chk(rcv_valid, 1, "R8 second word valid");
    chk(rcv_data, 8'hC3, "R8 second word value");
    rcv_done = 1'b1;
    nclk();
    rcv_done = 1'b0;
    repeat (3) nclk();
    chk(snd_ready, 1, "R8 link idle again");
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, failed);
    $finish;
  endtask

  initial begin
    #100000;
    total++; failed++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; snd_go = 1'b0; snd_data = '0; rcv_done = 1'b0;
    repeat (3) nclk();
    t_reset();
    rst_n = 1'b1;
    nclk();
    t_reset();
    t_alternate();
    t_busy_go();
    t_idle_done();
    t_back_to_back();
    t_alternate();
    finish_run();
  end
endmodule